// File: doc/BRIEF.md
# Configuration change protection unit

This block keeps four critical control registers from being changed by a stray store. It sits on an 8-bit I/O bus with address, write data, write strobe and combinational read data. It stores a clock source select register, a clock prescale register, a watchdog control register and an MCU control register. Some or all bits of each of these registers are guarded. A guarded bit changes only while an unlock window is open.

Software opens the window by writing the signature byte 0xD8 to the lock register at I/O address 0x3C. The window stays open for the next four instruction cycles. The CPU marks each instruction cycle with a one-clock strobe, and the unit counts those strobes. While the window is open the unit raises an interrupt-inhibit line to the interrupt controller. When the window closes, that line drops and the interrupt controller serves pending requests in priority order again. Unguarded bits can be written at any time. The actual clock switching, watchdog timing and brown-out logic are outside this block.

Top module: `cfgp_guard`

## Requirements
- R1: After reset all four held registers are 0x00, the lock register reads 0x00 and `irq_block` is low.
- R2: A write of 0xD8 to address 0x3C opens the window. A write of any other value to that address leaves a closed window closed.
- R3: The window stays open until four `cyc_stb` pulses have been seen after the cycle in which the signature was written. A strobe that arrives in the signature cycle itself is not counted.
- R4: `irq_block` is high exactly while the window is open.
- R5: Reading address 0x3C returns bit 0 = 1 while the window is open and 0 otherwise. Bits 7:1 always read 0.
- R6: Every bit of the clock source select register (address 0x37) and of the clock prescale register (address 0x36) is guarded. A write outside the window leaves the register unchanged. A write inside the window stores the full byte.
- R7: In the watchdog control register (address 0x31), only bits 4:0 are guarded: bit 4 is the enable and bits 3:0 are the prescaler select. Bits 7:5 take the written value at any time.
- R8: In the MCU control register (address 0x3A), only bit 7 (the sleep brown-out disable) is guarded. Bits 6:0 take the written value at any time.
- R9: Writing the signature again while the window is open restarts the full four-strobe count.
- R10: A guarded write does not close the window, so several guarded registers can be written in one window.
- R11: Reading one of the four register addresses returns that register's stored value. Any other unmapped address reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cyc_stb | input | 1 | One-clock pulse per CPU instruction cycle |
| io_addr | input | 6 | I/O address |
| io_wdata | input | 8 | Write data |
| io_we | input | 1 | Write strobe, one clock per write |
| io_rdata | output | 8 | Combinational read data for `io_addr` |
| irq_block | output | 1 | Interrupt inhibit, high while the window is open |
| clk_src_o | output | 8 | Clock source select register |
| clk_div_o | output | 8 | Clock prescale register |
| wdog_ctl_o | output | 8 | Watchdog control register |
| mcu_ctl_o | output | 8 | MCU control register |

## Verification
The bench builds the unit with its default parameters: a four-strobe window, the 0xD8 signature, and the addresses and guard masks listed above. With such a small register set, every register can be swept over all 256 data values three times: once locked, once unlocked, and once locked again. The lock address is swept over all 255 wrong values. The number of strobes between the signature and a guarded write is stepped from zero to five, which covers both sides of the window edge. Expected register contents come from the guard masks by arithmetic in the bench.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int NREG   = 4;

  typedef logic [DATA_W-1:0] cfg_byte_t;
  typedef logic [ADDR_W-1:0] cfg_addr_t;

  // register slot order inside the bank
  localparam int IDX_CLKSRC = 0;
  localparam int IDX_CLKDIV = 1;
  localparam int IDX_WDOG   = 2;
  localparam int IDX_MCU    = 3;
endpackage

// File: rtl/cfgp_window.sv
module cfgp_window #(
  parameter int WIN_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_stb,
  input  logic sig_hit,
  output logic open_o
);
  localparam int CNT_W = $clog2(WIN_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WIN_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // reload has priority over a strobe in the same cycle
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (sig_hit) begin
      cnt_d  = CNT_FULL;
      cnt_en = 1'b1;
    end else if (cyc_stb && (cnt_q != '0)) begin
      cnt_d  = cnt_q - CNT_W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign open_o = (cnt_q != '0);

  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
    sig_hit |=> (cnt_q == CNT_FULL));
  a_r3_hold_without_stb: assert property (@(posedge clk) disable iff (!rst_n)
    (!sig_hit && !cyc_stb) |=> $stable(cnt_q));
  a_r3_close_on_stb: assert property (@(posedge clk) disable iff (!rst_n)
    (open_o && !sig_hit && !cyc_stb) |=> open_o);
endmodule

// File: rtl/cfgp_reg.sv
module cfgp_reg #(
  parameter int                W     = 8,
  parameter logic [W-1:0]      GUARD = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic         unlock,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, q_d, wr_mask;

  // bits that a write may touch in this cycle
  assign wr_mask = unlock ? {W{1'b1}} : ~GUARD;

  always_comb begin
    q_d = (q_q & ~wr_mask) | (wdata & wr_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_q <= '0;
    else if (wr_hit) q_q <= q_d;
  end

  assign q_o = q_q;

  a_r6_guard_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !unlock |=> ((q_q & GUARD) == ($past(q_q) & GUARD)));
  a_r7_free_bits: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ((q_q & ~GUARD) == ($past(wdata) & ~GUARD)));
  a_r10_open_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && unlock) |=> (q_q == $past(wdata)));
endmodule

// File: rtl/cfgp_guard.sv
module cfgp_guard
  import cfgp_pkg::*;
#(
  parameter int                              WIN_CYC   = 4,
  parameter logic [DATA_W-1:0]               SIG       = 8'hD8,
  parameter logic [ADDR_W-1:0]               LOCK_ADDR = 6'h3C,
  parameter logic [NREG-1:0][ADDR_W-1:0]     REG_ADDR  = {6'h3A, 6'h31, 6'h36, 6'h37},
  parameter logic [NREG-1:0][DATA_W-1:0]     REG_GUARD = {8'h80, 8'h1F, 8'hFF, 8'hFF}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_stb,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              io_we,
  output logic [DATA_W-1:0] io_rdata,
  output logic              irq_block,
  output logic [DATA_W-1:0] clk_src_o,
  output logic [DATA_W-1:0] clk_div_o,
  output logic [DATA_W-1:0] wdog_ctl_o,
  output logic [DATA_W-1:0] mcu_ctl_o
);
  logic            sig_hit, unlocked;
  logic [NREG-1:0] wr_hit;
  cfg_byte_t       reg_q [NREG];

  assign sig_hit = io_we && (io_addr == LOCK_ADDR) && (io_wdata == SIG);

  cfgp_window #(.WIN_CYC(WIN_CYC)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .cyc_stb (cyc_stb),
    .sig_hit (sig_hit),
    .open_o  (unlocked)
  );

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_bank
      assign wr_hit[g] = io_we && (io_addr == REG_ADDR[g]);
      cfgp_reg #(.W(DATA_W), .GUARD(REG_GUARD[g])) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_hit[g]),
        .unlock (unlocked),
        .wdata  (io_wdata),
        .q_o    (reg_q[g])
      );
    end
  endgenerate

  always_comb begin
    io_rdata = '0;
    if (io_addr == LOCK_ADDR) io_rdata = {{(DATA_W-1){1'b0}}, unlocked};
    for (int i = 0; i < NREG; i++) begin
      if (io_addr == REG_ADDR[i]) io_rdata = reg_q[i];
    end
  end

  assign irq_block  = unlocked;
  assign clk_src_o  = reg_q[IDX_CLKSRC];
  assign clk_div_o  = reg_q[IDX_CLKDIV];
  assign wdog_ctl_o = reg_q[IDX_WDOG];
  assign mcu_ctl_o  = reg_q[IDX_MCU];

  a_r2_sig_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && io_addr == LOCK_ADDR && io_wdata == SIG) |=> irq_block);
  a_r2_other_stays_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we && io_addr == LOCK_ADDR && io_wdata != SIG && !irq_block) |=> !irq_block);
  a_r5_lock_read: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr == LOCK_ADDR) |-> (io_rdata[DATA_W-1:1] == '0 && io_rdata[0] == irq_block));
  a_r3_no_reopen: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_block && !sig_hit) |=> !irq_block);
endmodule

// File: tb/tb_cfgp_guard.sv
module tb_cfgp_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_stb = 1'b0;
  logic [5:0] io_addr = '0;
  logic [7:0] io_wdata = '0;
  logic       io_we = 1'b0;
  logic [7:0] io_rdata;
  logic       irq_block;
  logic [7:0] clk_src_o, clk_div_o, wdog_ctl_o, mcu_ctl_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q [4];
  logic [5:0] addr_of [4];
  logic [7:0] guard_of [4];

  always #5 clk = ~clk;

  cfgp_guard dut (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_we(io_we), .io_rdata(io_rdata),
    .irq_block(irq_block), .clk_src_o(clk_src_o), .clk_div_o(clk_div_o),
    .wdog_ctl_o(wdog_ctl_o), .mcu_ctl_o(mcu_ctl_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [5:0] a, input logic [7:0] d, input logic stb);
    io_we = we; io_addr = a; io_wdata = d; cyc_stb = stb;
    @(posedge clk); #1;
    io_we = 1'b0; cyc_stb = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    io_addr = a; #1; d = io_rdata;
  endtask

  function automatic logic [7:0] port_q(input int i);
    case (i)
      0: return clk_src_o;
      1: return clk_div_o;
      2: return wdog_ctl_o;
      default: return mcu_ctl_o;
    endcase
  endfunction

  task automatic close_win();
    repeat (4) cyc(1'b0, 6'h00, 8'h00, 1'b1);
  endtask

  task automatic check_reg(input string req, input int i);
    logic [7:0] r;
    chk(req, port_q(i), exp_q[i]);
    rd(addr_of[i], r);
    chk({req, " readback"}, r, exp_q[i]);
  endtask

  task automatic locked_sweep(input int i);
    for (int d = 0; d < 256; d++) begin
      cyc(1'b1, addr_of[i], 8'(d), 1'b0);
      exp_q[i] = (exp_q[i] & guard_of[i]) | (8'(d) & ~guard_of[i]);
      check_reg((i < 2) ? "R6 locked" : (i == 2) ? "R7 locked" : "R8 locked", i);
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    addr_of  = '{6'h37, 6'h36, 6'h31, 6'h3A};
    guard_of = '{8'hFF, 8'hFF, 8'h1F, 8'h80};
    for (int i = 0; i < 4; i++) exp_q[i] = 8'h00;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    for (int i = 0; i < 4; i++) check_reg("R1", i);
    rd(6'h3C, r); chk("R1 lock read", r, 8'h00);
    chk("R1 irq_block", {7'b0, irq_block}, 8'h00);
    // R11 unmapped
    rd(6'h00, r); chk("R11 unmapped 00", r, 8'h00);
    rd(6'h3F, r); chk("R11 unmapped 3F", r, 8'h00);

    // locked, unlocked, locked sweeps
    for (int i = 0; i < 4; i++) locked_sweep(i);
    for (int i = 0; i < 4; i++) begin
      for (int d = 0; d < 256; d++) begin
        cyc(1'b1, 6'h3C, 8'hD8, 1'b0);
        cyc(1'b1, addr_of[i], 8'(d), 1'b0);
        exp_q[i] = 8'(d);
        if (d % 64 == 0) begin
          rd(6'h3C, r); chk("R5 open read", r, 8'h01);
          chk("R4 irq high", {7'b0, irq_block}, 8'h01);
        end
        check_reg((i < 2) ? "R6 open" : (i == 2) ? "R7 open" : "R8 open", i);
      end
      close_win();
    end
    for (int i = 0; i < 4; i++) locked_sweep(i);

    // R3 window length
    for (int n = 0; n <= 5; n++) begin
      logic [7:0] v;
      cyc(1'b1, 6'h3C, 8'hD8, 1'b0);
      repeat (n) cyc(1'b0, 6'h00, 8'h00, 1'b1);
      chk("R4 irq vs strobes", {7'b0, irq_block}, (n < 4) ? 8'h01 : 8'h00);
      rd(6'h3C, r); chk("R5 lock read vs strobes", r, (n < 4) ? 8'h01 : 8'h00);
      v = exp_q[0] ^ 8'hFF;
      cyc(1'b1, addr_of[0], v, 1'b0);
      if (n < 4) exp_q[0] = v;
      check_reg("R3 window edge", 0);
      close_win();
    end

    // R3 strobe in signature cycle not counted
    cyc(1'b1, 6'h3C, 8'hD8, 1'b1);
    repeat (3) cyc(1'b0, 6'h00, 8'h00, 1'b1);
    chk("R3 sig-cycle strobe ignored", {7'b0, irq_block}, 8'h01);
    cyc(1'b0, 6'h00, 8'h00, 1'b1);
    chk("R3 closes after fourth", {7'b0, irq_block}, 8'h00);

    // R2 wrong signatures
    for (int v = 0; v < 256; v++) begin
      if (v == 8'hD8) continue;
      cyc(1'b1, 6'h3C, 8'(v), 1'b0);
      rd(6'h3C, r); chk("R2 wrong value stays locked", r, 8'h00);
      cyc(1'b1, addr_of[1], exp_q[1] ^ 8'hFF, 1'b0);
      check_reg("R2 wrong value no write", 1);
    end

    // R9 restart
    cyc(1'b1, 6'h3C, 8'hD8, 1'b0);
    repeat (3) cyc(1'b0, 6'h00, 8'h00, 1'b1);
    cyc(1'b1, 6'h3C, 8'hD8, 1'b0);
    repeat (3) cyc(1'b0, 6'h00, 8'h00, 1'b1);
    chk("R9 still open", {7'b0, irq_block}, 8'h01);
    exp_q[0] = exp_q[0] ^ 8'h5A;
    cyc(1'b1, addr_of[0], exp_q[0], 1'b0);
    check_reg("R9 write after restart", 0);
    cyc(1'b0, 6'h00, 8'h00, 1'b1);
    chk("R9 closes", {7'b0, irq_block}, 8'h00);

    // R10 several writes in one window, each on a strobe
    cyc(1'b1, 6'h3C, 8'hD8, 1'b0);
    for (int i = 0; i < 4; i++) begin
      exp_q[i] = exp_q[i] ^ 8'hFF;
      cyc(1'b1, addr_of[i], exp_q[i], 1'b1);
    end
    for (int i = 0; i < 4; i++) check_reg("R10 multi write", i);
    chk("R10 closed after four", {7'b0, irq_block}, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule